// File: doc/BRIEF.md
# Double-Buffered Converter Load Path

This block models the digital side of an 8-bit voltage-output converter. It has two registers in a row. A holding register takes the parallel bus. A conversion register takes the holding register, and only the conversion register drives the output code. Three active-low strobes control the two stages: a select, a shared write and a load. The holding stage is open while select and write are both low. The conversion stage is open while load and write are both low. When the write strobe goes high, both stages freeze at the value they last held.

The strobes and the bus come from an asynchronous source. They are passed through a two-stage synchronizer and then evaluated on the system clock, so that the level-sensitive latch behaviour is rebuilt from flip-flops. Next to the code, the block gives an ideal output value: the code as a fraction of a 16-bit reference word, `(ref * code) >> 8`. This value is registered on the same edge that updates the conversion register.

Top module: `dac_load_path`

## Requirements
- R1: A synchronous active-high reset clears the holding and conversion registers to code 0, so `dacCode` and `idealOut` read 0 after reset.
- R2: While `csN` and `wrN` are both low, the holding register follows `dataIn`.
- R3: While `ldN` and `wrN` are both low, the conversion register, and so `dacCode`, follows the holding register.
- R4: On the clock where the synchronized write strobe goes from 0 to 1, neither register takes a new value. Bus data that changes together with the write rise is not captured.
- R5: A value loaded into the holding register while `ldN` is high does not reach `dacCode` until a later transfer with `ldN` and `wrN` both low.
- R6: Taking `ldN` low while `wrN` is high leaves `dacCode` unchanged.
- R7: With `csN`, `wrN` and `ldN` all low, bus data passes through both stages to `dacCode`.
- R8: `idealOut` equals `(refWord * dacCode) >> 8`. At code 255 this is one LSB below the reference. The value is registered on the same edge as `dacCode`.
- R9: Strobes and bus are synchronized through two flip-flop stages. With both stages open, a bus change reaches `dacCode` on the fourth rising clock edge after it is applied, and not by the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csN | input | 1 | Active-low select for the holding stage |
| wrN | input | 1 | Active-low shared write strobe |
| ldN | input | 1 | Active-low load strobe for the conversion stage |
| dataIn | input | 8 | Parallel code bus |
| refWord | input | 16 | Reference word for the ideal output |
| dacCode | output | 8 | Conversion register contents |
| idealOut | output | 16 | Registered `(refWord * dacCode) >> 8` |

## Verification
Two events can fall in the same cycle: the write rise that closes both stages, and a bus change that would otherwise be captured. The bench provokes this by changing `dataIn` on the same step that raises `wrN`, and by random steps that change strobes and bus together. After the inputs settle, the result is judged against a level model of the two latches: the registers must keep the data from before the rise. The same bench model checks a transfer and a reference change that land together, through `idealOut`.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;
  typedef struct packed {
    logic inOpen;   // holding stage transparent
    logic dacOpen;  // conversion stage transparent
    logic wrRise;   // synchronized write just rose
  } ctrlStrobes_t;
endpackage

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
  import dac_load_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         csN,
  input  logic         wrN,
  input  logic         ldN,
  output ctrlStrobes_t strobes
);
  logic [SYNC_STAGES-1:0] csChain, wrChain, ldChain;
  logic wrPrev;
  logic csSync, wrSync, ldSync;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          csChain <= '1;
          wrChain <= '1;
          ldChain <= '1;
        end else begin
          csChain <= csN;
          wrChain <= wrN;
          ldChain <= ldN;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          csChain <= '1;
          wrChain <= '1;
          ldChain <= '1;
        end else begin
          csChain <= {csChain[SYNC_STAGES-2:0], csN};
          wrChain <= {wrChain[SYNC_STAGES-2:0], wrN};
          ldChain <= {ldChain[SYNC_STAGES-2:0], ldN};
        end
      end
    end
  endgenerate

  assign csSync = csChain[SYNC_STAGES-1];
  assign wrSync = wrChain[SYNC_STAGES-1];
  assign ldSync = ldChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) wrPrev <= 1'b1;
    else     wrPrev <= wrSync;
  end

  always_comb begin
    strobes.wrRise  = wrSync & ~wrPrev;
    strobes.inOpen  = ~csSync & ~wrSync;
    strobes.dacOpen = ~ldSync & ~wrSync;
  end

  AST_RISE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    strobes.wrRise |-> (!strobes.inOpen && !strobes.dacOpen)); // R4
  AST_LOAD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wrSync && !ldSync) |-> !strobes.dacOpen); // R6
endmodule

// File: rtl/dac_load_dp.sv
module dac_load_dp
  import dac_load_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int REF_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [REF_W-1:0]  refWord,
  output logic [DATA_W-1:0] dacCode,
  output logic [REF_W-1:0]  idealOut
);
  localparam int PROD_W = REF_W + DATA_W;

  logic [DATA_W-1:0] dataChain [SYNC_STAGES];
  logic [DATA_W-1:0] inReg, dacReg, dacNext;
  logic [PROD_W-1:0] product;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_dsync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) dataChain[0] <= '0;
        else     dataChain[0] <= dataIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) dataChain[s] <= '0;
        else     dataChain[s] <= dataChain[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 inReg <= '0;
    else if (strobes.inOpen) inReg <= dataChain[SYNC_STAGES-1];
  end

  always_comb begin
    dacNext = dacReg;
    if (strobes.dacOpen) dacNext = inReg;
    product = PROD_W'(refWord) * PROD_W'(dacNext);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dacReg   <= '0;
      idealOut <= '0;
    end else begin
      dacReg   <= dacNext;
      idealOut <= product[DATA_W +: REF_W];
    end
  end

  assign dacCode = dacReg;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (inReg == '0 && dacReg == '0)); // R1
  AST_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.inOpen |=> $stable(inReg)); // R2
  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.dacOpen |=> $stable(dacReg)); // R5
  AST_FREEZE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    strobes.wrRise |=> ($stable(inReg) && $stable(dacReg))); // R4
endmodule

// File: rtl/dac_load_path.sv
module dac_load_path
  import dac_load_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int REF_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              wrN,
  input  logic              ldN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [REF_W-1:0]  refWord,
  output logic [DATA_W-1:0] dacCode,
  output logic [REF_W-1:0]  idealOut
);
  ctrlStrobes_t strobes;

  dac_load_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .csN(csN), .wrN(wrN), .ldN(ldN), .strobes(strobes)
  );

  dac_load_dp #(.DATA_W(DATA_W), .REF_W(REF_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .dataIn(dataIn),
    .refWord(refWord), .dacCode(dacCode), .idealOut(idealOut)
  );
endmodule

// File: tb/dac_load_path_tb.sv
module dac_load_path_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csN = 1'b1, wrN = 1'b1, ldN = 1'b1;
  logic [7:0]  dataIn = '0;
  logic [15:0] refWord = 16'h0000;
  logic [7:0]  dacCode;
  logic [15:0] idealOut;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] mIn = '0, mDac = '0;

  always #10 clk = ~clk;

  dac_load_path u_dut (
    .clk(clk), .rst(rst), .csN(csN), .wrN(wrN), .ldN(ldN),
    .dataIn(dataIn), .refWord(refWord), .dacCode(dacCode), .idealOut(idealOut)
  );

  function automatic logic [15:0] idealOf(input logic [15:0] r, input logic [7:0] c);
    logic [23:0] p;
    p = {8'd0, r} * {16'd0, c};
    return p[23:8];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply a step at a negedge, let it settle, update the level model, check
  task automatic step(input logic c, input logic w, input logic l,
                      input logic [7:0] d, input string req);
    @(negedge clk);
    csN = c; wrN = w; ldN = l; dataIn = d;
    repeat (6) @(posedge clk);
    @(negedge clk);
    if (!c && !w) mIn = d;
    if (!l && !w) mDac = mIn;
    check({req, " code"}, {24'd0, dacCode}, {24'd0, mDac});
    check({req, " ideal R8"}, {16'd0, idealOut}, {16'd0, idealOf(refWord, mDac)});
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    refWord = 16'hA000;
    dataIn = 8'h5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 code after reset", {24'd0, dacCode}, 32'd0);
    check("R1 ideal after reset", {16'd0, idealOut}, 32'd0);
    rst = 1'b0;

    // R2 + R5: load holding register only, output stays 0
    step(1'b0, 1'b0, 1'b1, 8'h3C, "R5 hold load");
    check("R5 output unchanged", {24'd0, dacCode}, 32'd0);
    step(1'b1, 1'b1, 1'b1, 8'h3C, "R4 close");
    // R6: load low with write high
    step(1'b1, 1'b1, 1'b0, 8'h11, "R6 load no write");
    check("R6 code stays", {24'd0, dacCode}, 32'd0);
    // R3: transfer, which also shows R2 captured 3C
    step(1'b1, 1'b0, 1'b0, 8'h11, "R3 transfer");
    check("R2 R3 transferred", {24'd0, dacCode}, 32'h3C);
    step(1'b1, 1'b1, 1'b1, 8'h11, "R4 close2");
    // R7: all low, pass-through
    step(1'b0, 1'b0, 1'b0, 8'hC3, "R7 flow");
    check("R7 flow value", {24'd0, dacCode}, 32'hC3);
    // R4: write rises together with bus change
    step(1'b0, 1'b1, 1'b0, 8'h99, "R4 rise with data");
    check("R4 kept old", {24'd0, dacCode}, 32'hC3);
    // R8: full scale
    step(1'b0, 1'b0, 1'b0, 8'hFF, "R8 fullscale");
    check("R8 one LSB below ref", {16'd0, idealOut}, {16'd0, 16'hA000 - 16'h00A0});
    step(1'b0, 1'b1, 1'b0, 8'hFF, "R8 close");

    // R9: latency with both stages open
    @(negedge clk);
    csN = 1'b0; wrN = 1'b0; ldN = 1'b0; dataIn = 8'h42;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 not by edge 2", {24'd0, dacCode}, 32'hFF);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 at edge 4", {24'd0, dacCode}, 32'h42);
    check("R9 R8 ideal same edge", {16'd0, idealOut}, {16'd0, idealOf(refWord, 8'h42)});
    mIn = 8'h42; mDac = 8'h42;

    // random mix of strobes, bus and reference (R2 R3 R4 R5 R6 R7 R8)
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 8) == 0) refWord = 16'($urandom);
      step(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), "R2 R3 R4 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule